// File: doc/BRIEF.md
# Receive LAPD message controller

This block takes the bit-serial path-maintenance data link that a DS3 framer extracts from the line and recovers LAPD messages from it. It searches for flag-delimited frames, deletes the zeros that the sender inserted for transparency, assembles bytes least significant bit first, and writes the header and information bytes into a message buffer. The 16-bit frame check sequence is verified over the whole frame. A message that passes every check raises an interrupt status bit, and reading that bit clears it.

Software enables reception, selects which message lengths count as valid, and enables the interrupt through one control/status register. After an interrupt it reads the message length and the stored bytes through a buffer read port. Reception only runs while the framer reports DS3 operation with C-bit parity framing. While the status of a good message is still pending, the buffer keeps that message: later frames are neither stored nor reported.

Top module: `lapd_rx_ctrl`

## Requirements
- R1: After reset, reg_rdata reads 0x00, irq is low and rx_len is 0.
- R2: The flag 0x7E bounds each frame. Inside a frame, a 0 that follows five consecutive 1s is deleted. Bits are sent least significant bit first, so a good message's bytes sit at buffer addresses 0 to rx_len-1 in arrival order.
- R3: The last two bytes of a frame are the check sequence: the complement of the CRC-16 (x^16 + x^12 + x^5 + 1, register preset to all ones, LSB first) over the header and information bytes, low byte first. A mismatch, or a frame that does not end on a byte boundary, leaves the status unchanged.
- R4: Seven or more consecutive 1s abort the frame in progress. No status is raised for it, and reception resumes at the next flag.
- R5: Control bits [4:3] select the accepted message length (bytes excluding the check sequence): 0 any length from 1 to 82, 1 exactly 76, 2 exactly 82, 3 either 76 or 82. A frame of any other length, or one longer than 82 bytes, is discarded without status.
- R6: Frames are taken only while ds3_mode is 1, frame_fmt is 0 and control bit 2 (receive enable) is 1. Otherwise the receiver waits for a flag and raises no status.
- R7: Status (bit 0) rises on the clock edge that samples the last bit of the closing flag. At the same edge rx_len takes the message length.
- R8: irq is high exactly when status (bit 0) and interrupt enable (control bit 1) are both 1.
- R9: A read strobe on reg_rd clears status on that clock edge, unless a new message completes at the same edge. Writes cannot change bit 0.
- R10: While status is 1, rx_len and the buffer keep their contents. A frame whose opening flag arrives while status is 1 is dropped, even if status clears before the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ds3_mode | input | 1 | Framer reports DS3 operation when 1 |
| frame_fmt | input | 1 | Framer framing format; 0 means C-bit parity |
| dl_valid | input | 1 | dl_bit carries a data-link bit this cycle |
| dl_bit | input | 1 | Serial data-link bit |
| reg_wr | input | 1 | Write strobe for the control/status register |
| reg_rd | input | 1 | Read strobe; clears status |
| reg_wdata | input | 8 | Write data: [4:3] length mode, [2] receive enable, [1] interrupt enable |
| reg_rdata | output | 8 | {3'b0, length mode, receive enable, interrupt enable, status} |
| irq | output | 1 | Interrupt request |
| buf_addr | input | 7 | Message buffer read address |
| buf_data | output | 8 | Message byte at buf_addr (combinational) |
| rx_len | output | 7 | Length of the last good message |

## Verification
Every internal error of this block surfaces at the status bit, at irq or at rx_len. A wrong ones count, bit index or check register either hides a good message or reports a bad one, and the error shows on the clock edge of the closing flag's last bit. A bench model fed the same bits predicts those three values on every cycle, so a fault is caught on that edge and not at the end of a scenario. Storage faults appear only as wrong bytes when the buffer is read, so the bench reads every stored byte back after each good message.

// File: rtl/lapd_rx_pkg.sv
package lapd_rx_pkg;
  localparam int unsigned LAPD_MAX_LEN = 82;
  localparam int unsigned LAPD_STD_LEN = 76;

  localparam logic [15:0] FCS_INIT    = 16'hFFFF;
  localparam logic [15:0] FCS_POLY_R  = 16'h8408;
  localparam logic [15:0] FCS_RESIDUE = 16'hF0B8;

  typedef enum logic [1:0] {
    LEN_VAR     = 2'd0,
    LEN_SHORT   = 2'd1,
    LEN_LONG    = 2'd2,
    LEN_STD_ANY = 2'd3
  } len_mode_e;

  // one byte through the reflected CRC-16, least significant bit first
  function automatic logic [15:0] fcs_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ FCS_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/lapd_deframer.sv
module lapd_deframer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_on,
  input  logic       bit_vld,
  input  logic       bit_in,
  output logic       byte_stb,
  output logic [7:0] byte_val,
  output logic       flag_stb,
  output logic       end_ok
);
  logic [2:0] ones_q, ones_d;
  logic       in_q, in_d;
  logic [2:0] nb_q, nb_d;
  logic [6:0] sr_q, sr_d;
  logic       data_take;
  logic       upd_en;

  assign upd_en = !link_on || bit_vld;

  always_comb begin
    ones_d    = ones_q;
    in_d      = in_q;
    nb_d      = nb_q;
    sr_d      = sr_q;
    data_take = 1'b0;
    flag_stb  = 1'b0;
    end_ok    = 1'b0;
    byte_stb  = 1'b0;
    byte_val  = {bit_in, sr_q};
    if (!link_on) begin
      ones_d = '0;
      in_d   = 1'b0;
      nb_d   = '0;
    end else if (bit_vld) begin
      if (bit_in) begin
        if (ones_q == 3'd6) begin
          in_d   = 1'b0;          // seventh one: abort
          ones_d = 3'd7;
        end else if (ones_q == 3'd7) begin
          ones_d = 3'd7;
        end else begin
          ones_d    = ones_q + 3'd1;
          data_take = 1'b1;
        end
      end else begin
        ones_d = '0;
        if (ones_q == 3'd6) begin
          flag_stb = 1'b1;
          end_ok   = in_q && (nb_q == 3'd7);
          in_d     = 1'b1;
          nb_d     = '0;
        end else if (ones_q < 3'd5) begin
          data_take = 1'b1;
        end
      end
      if (data_take && in_q) begin
        if (nb_q == 3'd7) begin
          byte_stb = 1'b1;
          nb_d     = '0;
        end else begin
          sr_d[nb_q] = bit_in;
          nb_d       = nb_q + 3'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      in_q   <= 1'b0;
      nb_q   <= '0;
      sr_q   <= '0;
    end else if (upd_en) begin
      ones_q <= ones_d;
      in_q   <= in_d;
      nb_q   <= nb_d;
      sr_q   <= sr_d;
    end
  end
endmodule

// File: rtl/lapd_fcs16.sv
module lapd_fcs16
  import lapd_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       byte_stb,
  input  logic [7:0] byte_val,
  output logic       fcs_good
);
  logic [15:0] crc_q, crc_d;
  logic        crc_en;

  assign crc_en = restart || byte_stb;

  always_comb begin
    if (restart) crc_d = FCS_INIT;
    else         crc_d = fcs_step(crc_q, byte_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= FCS_INIT;
    else if (crc_en) crc_q <= crc_d;
  end

  assign fcs_good = (crc_q == FCS_RESIDUE);
endmodule

// File: rtl/lapd_msg_store.sv
module lapd_msg_store
  import lapd_rx_pkg::*;
#(
  parameter  int unsigned MAX_LEN = LAPD_MAX_LEN,
  parameter  int unsigned STD_LEN = LAPD_STD_LEN,
  localparam int unsigned DEPTH   = MAX_LEN + 2,
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned LW      = $clog2(MAX_LEN + 1),
  localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_stb,
  input  logic [7:0]    byte_val,
  input  logic          flag_stb,
  input  logic          end_ok,
  input  logic          fcs_good,
  input  len_mode_e     len_mode,
  input  logic          pending,
  input  logic [AW-1:0] rd_addr,
  output logic          done_good,
  output logic [LW-1:0] msg_len,
  output logic [7:0]    rd_data
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] MAX_C   = CW'(MAX_LEN);
  localparam logic [CW-1:0] STD_C   = CW'(STD_LEN);
  localparam logic [CW-1:0] TWO_C   = CW'(2);
  localparam logic [CW-1:0] THREE_C = CW'(3);
  localparam logic [AW-1:0] ADDR_LIM = AW'(DEPTH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          take_q, take_d;
  logic [LW-1:0] len_q;
  logic          wr_en;
  logic          len_fit;
  logic [CW-1:0] body_len;
  logic [7:0]    rd_vec [DEPTH];

  assign body_len = cnt_q - TWO_C;

  always_comb begin
    unique case (len_mode)
      LEN_VAR:     len_fit = (body_len <= MAX_C);
      LEN_SHORT:   len_fit = (body_len == STD_C);
      LEN_LONG:    len_fit = (body_len == MAX_C);
      default:     len_fit = (body_len == STD_C) || (body_len == MAX_C);
    endcase
  end

  assign done_good = flag_stb && end_ok && take_q && !ovf_q && (cnt_q >= THREE_C)
                     && fcs_good && len_fit;

  assign wr_en = byte_stb && take_q && (cnt_q != DEPTH_C);

  always_comb begin
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    take_d = take_q;
    if (flag_stb) begin
      cnt_d  = '0;
      ovf_d  = 1'b0;
      take_d = !(pending || done_good);
    end else if (byte_stb) begin
      if (cnt_q == DEPTH_C) ovf_d = 1'b1;
      else                  cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      take_q <= 1'b0;
    end else if (flag_stb || byte_stb) begin
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
      take_q <= take_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         len_q <= '0;
    else if (done_good) len_q <= LW'(body_len);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [7:0] cell_q;
    always_ff @(posedge clk) begin
      if (wr_en && (cnt_q == CW'(g))) cell_q <= byte_val;
    end
    assign rd_vec[g] = cell_q;
  end

  assign rd_data = (rd_addr < ADDR_LIM) ? rd_vec[rd_addr] : 8'h00;
  assign msg_len = len_q;
endmodule

// File: rtl/lapd_rx_ctrl.sv
module lapd_rx_ctrl
  import lapd_rx_pkg::*;
#(
  parameter  int unsigned MAX_LEN = LAPD_MAX_LEN,
  parameter  int unsigned STD_LEN = LAPD_STD_LEN,
  localparam int unsigned DEPTH   = MAX_LEN + 2,
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned LW      = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ds3_mode,
  input  logic          frame_fmt,
  input  logic          dl_valid,
  input  logic          dl_bit,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq,
  input  logic [AW-1:0] buf_addr,
  output logic [7:0]    buf_data,
  output logic [LW-1:0] rx_len
);
  logic       rs1_q, rs2_q, rst_i;
  logic       en_q, en_d, ien_q, ien_d, st_q, st_d;
  len_mode_e  mode_q, mode_d;
  logic       link_on;
  logic       byte_stb, flag_stb, end_ok, fcs_good, done_good;
  logic [7:0] byte_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i = rs2_q;

  assign link_on = en_q && ds3_mode && !frame_fmt;

  lapd_deframer u_dfr (
    .clk(clk), .rst_n(rst_i), .link_on(link_on), .bit_vld(dl_valid), .bit_in(dl_bit),
    .byte_stb(byte_stb), .byte_val(byte_val), .flag_stb(flag_stb), .end_ok(end_ok)
  );

  lapd_fcs16 u_fcs (
    .clk(clk), .rst_n(rst_i), .restart(flag_stb), .byte_stb(byte_stb),
    .byte_val(byte_val), .fcs_good(fcs_good)
  );

  lapd_msg_store #(.MAX_LEN(MAX_LEN), .STD_LEN(STD_LEN)) u_store (
    .clk(clk), .rst_n(rst_i), .byte_stb(byte_stb), .byte_val(byte_val),
    .flag_stb(flag_stb), .end_ok(end_ok), .fcs_good(fcs_good), .len_mode(mode_q),
    .pending(st_q), .rd_addr(buf_addr), .done_good(done_good), .msg_len(rx_len),
    .rd_data(buf_data)
  );

  always_comb begin
    en_d   = en_q;
    ien_d  = ien_q;
    mode_d = mode_q;
    if (reg_wr) begin
      en_d   = reg_wdata[2];
      ien_d  = reg_wdata[1];
      mode_d = len_mode_e'(reg_wdata[4:3]);
    end
    if (done_good)   st_d = 1'b1;
    else if (reg_rd) st_d = 1'b0;
    else             st_d = st_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      en_q   <= 1'b0;
      ien_q  <= 1'b0;
      mode_q <= LEN_VAR;
    end else if (reg_wr) begin
      en_q   <= en_d;
      ien_q  <= ien_d;
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)                  st_q <= 1'b0;
    else if (done_good || reg_rd) st_q <= st_d;
  end

  assign reg_rdata = {3'b000, mode_q, en_q, ien_q, st_q};
  assign irq       = st_q && ien_q;
endmodule

// File: rtl/lapd_rx_ctrl_chk.sv
module lapd_rx_ctrl_chk #(
  parameter  int unsigned MAX_LEN = 82,
  parameter  int unsigned STD_LEN = 76,
  localparam int unsigned LW      = $clog2(MAX_LEN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ds3_mode,
  input logic          frame_fmt,
  input logic          dl_valid,
  input logic          dl_bit,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [7:0]    reg_rdata,
  input logic          irq,
  input logic [LW-1:0] rx_len,
  input logic          done_good
);
  localparam logic [LW-1:0] MAX_L = LW'(MAX_LEN);
  localparam logic [LW-1:0] STD_L = LW'(STD_LEN);
  localparam logic [LW-1:0] ONE_L = LW'(1);

  // R9
  clr_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !done_good) |=> !reg_rdata[0]);

  // R10
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[0] |=> $stable(rx_len));

  // R6
  link_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ds3_mode && !frame_fmt && reg_rdata[2]) |=> !$rose(reg_rdata[0]));

  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(reg_rdata[0]) && reg_rdata[1]) |-> irq);

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (reg_rdata[0] && reg_rdata[1]));

  // R7
  flag_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[0]) |-> ($past(dl_valid) && !$past(dl_bit)));

  // R5
  len_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(reg_rdata[0]) && !$past(reg_wr)) |->
      ((reg_rdata[4:3] == 2'd0 && rx_len >= ONE_L && rx_len <= MAX_L) ||
       (reg_rdata[4:3] == 2'd1 && rx_len == STD_L) ||
       (reg_rdata[4:3] == 2'd2 && rx_len == MAX_L) ||
       (reg_rdata[4:3] == 2'd3 && (rx_len == STD_L || rx_len == MAX_L))));
endmodule

bind lapd_rx_ctrl lapd_rx_ctrl_chk #(.MAX_LEN(MAX_LEN), .STD_LEN(STD_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .ds3_mode(ds3_mode), .frame_fmt(frame_fmt),
  .dl_valid(dl_valid), .dl_bit(dl_bit), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_rdata(reg_rdata), .irq(irq), .rx_len(rx_len), .done_good(done_good)
);

// File: tb/sim_lapd_rx_ctrl.sv
`timescale 1ns/1ps
module sim_lapd_rx_ctrl;
  typedef logic [7:0] bq_t [$];

  logic       clk, rst_n, ds3_mode, frame_fmt, dl_valid, dl_bit, reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata, buf_data;
  logic       irq;
  logic [6:0] buf_addr, rx_len;

  int    checks = 0, fails = 0;
  string cur_req = "R1";
  bit    model_on = 0;
  bit    txq [$];
  int    st_ones;

  // behavioural reference state
  int m_ones, m_nb, m_len;
  bit m_in, m_take, m_ovf, m_en, m_ien, m_st;
  int m_mode;
  logic [7:0] m_cur;
  logic [7:0] m_q [$];

  lapd_rx_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ds3_mode(ds3_mode), .frame_fmt(frame_fmt),
    .dl_valid(dl_valid), .dl_bit(dl_bit), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .buf_addr(buf_addr),
    .buf_data(buf_data), .rx_len(rx_len)
  );

  initial clk = 0;
  always #2 clk = ~clk;   // 250 MHz

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] bench_fcs(input bq_t d, input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        bit fb = c[0] ^ d[i][k];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  function automatic bit len_accept(input int n);
    case (m_mode)
      0: return n >= 1 && n <= 82;
      1: return n == 76;
      2: return n == 82;
      default: return n == 76 || n == 82;
    endcase
  endfunction

  task automatic m_data(input bit b);
    if (!m_in) return;
    m_cur[m_nb] = b;
    m_nb++;
    if (m_nb == 8) begin
      if (m_q.size() >= 84) m_ovf = 1;
      else m_q.push_back(m_cur);
      m_nb = 0;
    end
  endtask

  // reference model, one step per clock
  always @(posedge clk) if (model_on) begin
    bit done, link;
    int n;
    logic [15:0] f;
    done = 0;
    link = m_en && ds3_mode && !frame_fmt;
    if (!link) begin
      m_ones = 0; m_in = 0; m_nb = 0;
    end else if (dl_valid) begin
      if (dl_bit) begin
        if (m_ones == 6) begin m_in = 0; m_ones = 7; end
        else if (m_ones >= 7) m_ones = 7;
        else begin m_ones++; m_data(1); end
      end else begin
        if (m_ones == 6) begin
          if (m_in && m_nb == 7 && m_take && !m_ovf && m_q.size() >= 3) begin
            n = m_q.size() - 2;
            f = bench_fcs(m_q, n);
            if (m_q[n] == f[7:0] && m_q[n+1] == f[15:8] && len_accept(n)) begin
              done = 1; m_len = n;
            end
          end
          m_take = !(m_st || done);
          m_q.delete(); m_ovf = 0; m_nb = 0; m_in = 1;
        end else if (m_ones < 5) m_data(0);
        m_ones = 0;
      end
    end
    if (done) m_st = 1;
    else if (reg_rd) m_st = 0;
    if (reg_wr) begin
      m_en = reg_wdata[2]; m_ien = reg_wdata[1]; m_mode = int'(reg_wdata[4:3]);
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) if (model_on) begin
    logic [15:0] act, exp;
    act = {rx_len, irq, reg_rdata};
    exp = {7'(m_len), m_st && m_ien, 3'b000, 2'(m_mode), m_en, m_ien, m_st};
    chk(act == exp, cur_req, "per-cycle {rx_len,irq,reg}", int'(act), int'(exp));
  end

  task automatic put_raw(input logic [7:0] b);
    for (int i = 0; i < 8; i++) txq.push_back(b[i]);
  endtask

  task automatic put_stuffed(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      txq.push_back(b[i]);
      if (b[i]) begin
        st_ones++;
        if (st_ones == 5) begin txq.push_back(1'b0); st_ones = 0; end
      end else st_ones = 0;
    end
  endtask

  task automatic build(input bq_t d, input bit corrupt, input int abort_at);
    logic [15:0] f;
    st_ones = 0;
    put_raw(8'h7E);
    for (int i = 0; i < d.size(); i++) begin
      if (i == abort_at) begin
        for (int k = 0; k < 8; k++) txq.push_back(1'b1);
        put_raw(8'h7E);
        return;
      end
      put_stuffed(d[i]);
    end
    f = bench_fcs(d, d.size());
    if (corrupt) f = f ^ 16'h0001;
    put_stuffed(f[7:0]);
    put_stuffed(f[15:8]);
    put_raw(8'h7E);
  endtask

  function automatic bq_t mk(input int n, input int seed);
    bq_t q;
    for (int i = 0; i < n; i++) q.push_back((i % 7 == 3) ? 8'hFF : 8'((i * 37 + seed) & 8'hFF));
    return q;
  endfunction

  task automatic send_n(input int n);
    int k = 0;
    while (txq.size() > 0 && k < n) begin
      @(negedge clk);
      if (k % 4 == 3) begin
        dl_valid = 0;
        @(negedge clk);
      end
      dl_valid = 1;
      dl_bit   = txq.pop_front();
      k++;
    end
    @(negedge clk);
    dl_valid = 0;
  endtask

  task automatic send_all();
    send_n(1000000);
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_status();
    @(negedge clk); reg_rd = 1;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic expect_st(input bit e, input string req);
    @(negedge clk);
    chk(reg_rdata[0] == e, req, "status bit", int'(reg_rdata[0]), int'(e));
  endtask

  task automatic check_buf(input bq_t d, input string req);
    chk(rx_len == 7'(d.size()), req, "rx_len", int'(rx_len), d.size());
    for (int i = 0; i < d.size(); i++) begin
      @(negedge clk); buf_addr = 7'(i); #1;
      chk(buf_data == d[i], req, $sformatf("buffer byte %0d", i), int'(buf_data), int'(d[i]));
    end
  endtask

  task automatic frame(input bq_t d, input bit corrupt, input int abort_at);
    build(d, corrupt, abort_at);
    send_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bq_t a, b;
    rst_n = 0; ds3_mode = 1; frame_fmt = 0; dl_valid = 0; dl_bit = 0;
    reg_wr = 0; reg_rd = 0; reg_wdata = 0; buf_addr = 0;
    m_ones = 0; m_nb = 0; m_len = 0; m_in = 0; m_take = 0; m_ovf = 0;
    m_en = 0; m_ien = 0; m_st = 0; m_mode = 0; m_cur = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    model_on = 1;
    // R1 reset state
    chk(reg_rdata == 8'h00 && !irq && rx_len == 0, "R1", "reset outputs",
        int'({rx_len, irq, reg_rdata}), 0);

    // R2 R7 R8: short variable message with flag pattern and long ones runs
    cur_req = "R2";
    wr_ctrl(8'b0000_0110);
    a = {8'h7E, 8'hFF, 8'h7D, 8'h1F, 8'h00};
    frame(a, 0, -1);
    expect_st(1, "R7");
    chk(irq == 1, "R8", "irq with enable", int'(irq), 1);
    check_buf(a, "R2");

    // R10: frame during pending status is not stored
    cur_req = "R10";
    frame(mk(4, 9), 0, -1);
    check_buf(a, "R10");
    // R9: read clears status
    cur_req = "R9";
    rd_status();
    expect_st(0, "R9");
    chk(irq == 0, "R8", "irq after clear", int'(irq), 0);
    wr_ctrl(8'b0000_0111);   // bit0 not writable
    expect_st(0, "R9");

    // R10: opening flag while pending, clear mid-frame
    cur_req = "R10";
    frame(mk(6, 3), 0, -1);
    expect_st(1, "R10");
    build(mk(8, 5), 0, -1);
    send_n(40);
    rd_status();
    send_all();
    expect_st(0, "R10");

    // R3 corrupted check sequence
    cur_req = "R3";
    frame(mk(10, 1), 1, -1);
    expect_st(0, "R3");
    b = mk(12, 77);
    frame(b, 0, -1);
    expect_st(1, "R3");
    check_buf(b, "R3");
    rd_status();

    // R4 abort
    cur_req = "R4";
    frame(mk(20, 2), 0, 9);
    expect_st(0, "R4");
    frame(mk(3, 2), 0, -1);
    expect_st(1, "R4");
    rd_status();

    // R5 length modes
    cur_req = "R5";
    wr_ctrl(8'b0000_1110);
    b = mk(76, 4);
    frame(b, 0, -1);
    expect_st(1, "R5");
    check_buf(b, "R5");
    rd_status();
    frame(mk(10, 4), 0, -1);
    expect_st(0, "R5");
    wr_ctrl(8'b0001_0110);
    frame(mk(76, 6), 0, -1);
    expect_st(0, "R5");
    b = mk(82, 8);
    frame(b, 0, -1);
    expect_st(1, "R5");
    check_buf(b, "R5");
    rd_status();
    wr_ctrl(8'b0001_1110);
    frame(mk(76, 11), 0, -1);
    expect_st(1, "R5");
    rd_status();
    wr_ctrl(8'b0000_0110);
    frame(mk(83, 12), 0, -1);
    expect_st(0, "R5");
    frame(mk(90, 13), 0, -1);
    expect_st(0, "R5");
    frame(mk(82, 14), 0, -1);
    expect_st(1, "R5");
    rd_status();

    // R6 qualifiers
    cur_req = "R6";
    frame_fmt = 1;
    frame(mk(5, 20), 0, -1);
    expect_st(0, "R6");
    frame_fmt = 0; ds3_mode = 0;
    frame(mk(5, 21), 0, -1);
    expect_st(0, "R6");
    ds3_mode = 1;
    wr_ctrl(8'b0000_0010);
    frame(mk(5, 22), 0, -1);
    expect_st(0, "R6");

    // R8 interrupt disabled
    cur_req = "R8";
    wr_ctrl(8'b0000_0100);
    frame(mk(7, 23), 0, -1);
    expect_st(1, "R8");
    chk(irq == 0, "R8", "irq without enable", int'(irq), 0);
    rd_status();
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule